// File: doc/BRIEF.md
# Parking Address-Bus Arbiter Pair with Disable Mask

This block arbitrates the address phase of two independent internal buses. Each bus has its own arbiter that serves up to sixteen initiators. The grant is held in an owner register and parks on the initiator that last won the bus. A new decision is taken only when the bus reports that the current address transfer has finished or that the bus is idle. At that point the next owner is chosen round-robin among the initiators that are both requesting and enabled.

A single 32-bit control register holds one disable bit per initiator. The low half serves bus A and the high half serves bus B. A set bit does not stop the initiator itself. It only keeps that initiator from winning a new arbitration. Because the mask is consulted only when an arbitration takes place, a parked owner whose bit is set keeps its grant until some eligible initiator requests the bus. Bits that belong to no implemented initiator read as zero, and writes to them have no effect.

Top module: `park_arb_pair`

## Requirements
- R1: After reset each bus grants initiator 0 (grant value 1), each grant-valid flag is 0, and the control register reads 0.
- R2: Each grant output has exactly one bit set in every cycle.
- R3: A grant changes only at a clock edge where that bus's done input is high.
- R4: At an edge where done is high and at least one initiator is eligible (request high and disable bit 0), the new owner is the first eligible index after the current owner, in ascending order with wrap-around; the current owner is considered last. The grant-valid flag is then 1.
- R5: At an edge where done is high and no initiator is eligible, the grant stays parked on the current owner and grant-valid becomes 0.
- R6: An initiator whose disable bit is 1 never becomes the new owner. A mask value written in a cycle is used first by arbitrations at later edges; an arbitration at the same edge as the write uses the old mask.
- R7: A parked owner whose disable bit is set keeps the grant through done cycles with no eligible request, and loses it at the first arbitration that has an eligible requester.
- R8: If every requesting initiator is disabled, an arbitration leaves the grant on the current owner, even when that owner is itself requesting.
- R9: Control bit i (0 to N_A-1) is the disable bit of bus A initiator i; control bit 16+i (i from 0 to N_B-1) is the disable bit of bus B initiator i.
- R10: Control bits N_A to 15 and 16+N_B to 31 read 0 and ignore writes; all other bits read back the last value written.
- R11: Activity on one bus leaves the grant and grant-valid flag of the other bus unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 32 | Write data for the control register |
| cfg_rdata | output | 32 | Current control register value |
| a_req | input | N_A | Bus A request lines, one per initiator |
| a_done | input | 1 | Bus A transfer-done / idle, opens an arbitration |
| a_gnt | output | N_A | Bus A one-hot grant |
| a_gnt_vld | output | 1 | Bus A grant came from an arbitration with a winner |
| b_req | input | N_B | Bus B request lines, one per initiator |
| b_done | input | 1 | Bus B transfer-done / idle, opens an arbitration |
| b_gnt | output | N_B | Bus B one-hot grant |
| b_gnt_vld | output | 1 | Bus B grant came from an arbitration with a winner |

## Verification
A register write that changes disable bits can fall at the very edge where one or both buses arbitrate, so the decision must use the mask as it stood before the write. The bench provokes this with random writes mixed into random request and done patterns on both buses, and a reference model resolves each arbitration with the old mask before it applies the write. Directed cases also write the disable bit of a parked owner and then judge the grant over idle done cycles, over a cycle where only that owner requests, and over a cycle where another enabled initiator requests.

// File: rtl/park_arb_pkg.sv
package park_arb_pkg;
   localparam int CFG_W  = 32;
   localparam int HALF_W = 16;

   // Bits of one register half that back a real initiator.
   function automatic logic [HALF_W-1:0] impl_bits(input int n);
      logic [HALF_W-1:0] m;
      m = '0;
      for (int i = 0; i < HALF_W; i++) begin
         if (i < n) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/park_arb_cfg_reg.sv
module park_arb_cfg_reg
   import park_arb_pkg::*;
#(
   parameter int N_A = 12,
   parameter int N_B = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata
);
   localparam logic [CFG_W-1:0] WMASK = {impl_bits(N_B), impl_bits(N_A)};

   logic [CFG_W-1:0] bits;

   // Only implemented bits get a flop; reserved bits are tied to zero.
   for (genvar i = 0; i < CFG_W; i++) begin : g_bit
      if (WMASK[i]) begin : g_impl
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)  q <= 1'b0;
            else if (we) q <= wdata[i];
         end
         assign bits[i] = q;
      end else begin : g_resv
         assign bits[i] = 1'b0;
      end
   end

   assign rdata = bits;
endmodule

// File: rtl/park_arb_rr_pick.sv
module park_arb_rr_pick #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic [IW-1:0] owner,
   input  logic [N-1:0]  elig,
   output logic          found,
   output logic [IW-1:0] win
);
   // Scan from owner+1 upward with wrap; the owner itself is seen last.
   always_comb begin
      int unsigned idx;
      found = 1'b0;
      win   = owner;
      idx   = 0;
      for (int k = 1; k <= N; k++) begin
         idx = (int'(owner) + k) % N;
         if (!found && elig[idx]) begin
            found = 1'b1;
            win   = IW'(idx);
         end
      end
   end
endmodule

// File: rtl/park_arb_core.sv
module park_arb_core #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         done,
   input  logic [N-1:0] dis_mask,
   output logic [N-1:0] gnt,
   output logic         gnt_vld
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   logic [IW-1:0] owner_q;
   logic          vld_q;
   logic [N-1:0]  elig;
   logic          found;
   logic [IW-1:0] win;

   assign elig = req & ~dis_mask;

   park_arb_rr_pick #(.N(N), .IW(IW)) u_pick (
      .owner (owner_q),
      .elig  (elig),
      .found (found),
      .win   (win)
   );

   // The mask is only looked at here, when done opens an arbitration.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q <= '0;
         vld_q   <= 1'b0;
      end else if (done) begin
         if (found) begin
            owner_q <= win;
            vld_q   <= 1'b1;
         end else begin
            vld_q   <= 1'b0;
         end
      end
   end

   always_comb begin
      gnt          = '0;
      gnt[owner_q] = 1'b1;
   end

   assign gnt_vld = vld_q;
endmodule

// File: rtl/park_arb_pair.sv
module park_arb_pair
   import park_arb_pkg::*;
#(
   parameter int N_A = 12,
   parameter int N_B = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic [N_A-1:0]   a_req,
   input  logic             a_done,
   output logic [N_A-1:0]   a_gnt,
   output logic             a_gnt_vld,
   input  logic [N_B-1:0]   b_req,
   input  logic             b_done,
   output logic [N_B-1:0]   b_gnt,
   output logic             b_gnt_vld
);
   if (N_A < 1 || N_A > HALF_W) begin : g_bad_na
      $error("park_arb_pair: N_A must lie in 1..16");
   end
   if (N_B < 1 || N_B > HALF_W) begin : g_bad_nb
      $error("park_arb_pair: N_B must lie in 1..16");
   end

   park_arb_cfg_reg #(.N_A(N_A), .N_B(N_B)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata)
   );

   park_arb_core #(.N(N_A)) u_bus_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (a_req),
      .done     (a_done),
      .dis_mask (cfg_rdata[N_A-1:0]),
      .gnt      (a_gnt),
      .gnt_vld  (a_gnt_vld)
   );

   park_arb_core #(.N(N_B)) u_bus_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (b_req),
      .done     (b_done),
      .dis_mask (cfg_rdata[HALF_W +: N_B]),
      .gnt      (b_gnt),
      .gnt_vld  (b_gnt_vld)
   );
endmodule

// File: rtl/park_arb_chk.sv
module park_arb_chk
   import park_arb_pkg::*;
#(
   parameter int N_A = 12,
   parameter int N_B = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CFG_W-1:0] cfg_rdata,
   input logic [N_A-1:0]   a_req,
   input logic             a_done,
   input logic [N_A-1:0]   a_gnt,
   input logic             a_gnt_vld,
   input logic [N_B-1:0]   b_req,
   input logic             b_done,
   input logic [N_B-1:0]   b_gnt,
   input logic             b_gnt_vld
);
   localparam logic [CFG_W-1:0] IMPL = {impl_bits(N_B), impl_bits(N_A)};

   logic [N_A-1:0] a_elig;
   logic [N_B-1:0] b_elig;
   assign a_elig = a_req & ~cfg_rdata[N_A-1:0];
   assign b_elig = b_req & ~cfg_rdata[HALF_W +: N_B];

   // R2
   a_r2_onehot_a: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(a_gnt) == 1);
   a_r2_onehot_b: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(b_gnt) == 1);

   // R3
   a_r3_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
      !a_done |=> $stable(a_gnt));
   a_r3_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
      !b_done |=> $stable(b_gnt));

   // R4 and R6: winner was eligible under the mask seen at that edge
   a_r4_win_a: assert property (@(posedge clk) disable iff (!rst_n)
      (a_done && (a_elig != '0)) |=> (a_gnt_vld && ((a_gnt & $past(a_elig)) != '0)));
   a_r4_win_b: assert property (@(posedge clk) disable iff (!rst_n)
      (b_done && (b_elig != '0)) |=> (b_gnt_vld && ((b_gnt & $past(b_elig)) != '0)));

   // R5 and R8
   a_r5_park_a: assert property (@(posedge clk) disable iff (!rst_n)
      (a_done && (a_elig == '0)) |=> ($stable(a_gnt) && !a_gnt_vld));
   a_r5_park_b: assert property (@(posedge clk) disable iff (!rst_n)
      (b_done && (b_elig == '0)) |=> ($stable(b_gnt) && !b_gnt_vld));

   // R10
   a_r10_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~IMPL) == '0);
endmodule

bind park_arb_pair park_arb_chk #(.N_A(N_A), .N_B(N_B)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_rdata (cfg_rdata),
   .a_req     (a_req),
   .a_done    (a_done),
   .a_gnt     (a_gnt),
   .a_gnt_vld (a_gnt_vld),
   .b_req     (b_req),
   .b_done    (b_done),
   .b_gnt     (b_gnt),
   .b_gnt_vld (b_gnt_vld)
);

// File: tb/tb_park_arb_pair.sv
`timescale 1ns/1ps
module tb_park_arb_pair;
   localparam int NA = 12;
   localparam int NB = 10;
   localparam logic [31:0] IMPL = {6'b0, {NB{1'b1}}, 4'b0, {NA{1'b1}}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic [NA-1:0] a_req = '0;
   logic          a_done = 1'b0;
   logic [NA-1:0] a_gnt;
   logic          a_gnt_vld;
   logic [NB-1:0] b_req = '0;
   logic          b_done = 1'b0;
   logic [NB-1:0] b_gnt;
   logic          b_gnt_vld;

   always #5 clk = ~clk;

   park_arb_pair #(.N_A(NA), .N_B(NB)) dut (.*);

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   int own_a, own_b;
   bit vld_a, vld_b;
   logic [31:0] reg_m;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int pick(input int own, input logic [15:0] elig, input int n);
      for (int k = 1; k <= n; k++) begin
         int idx;
         idx = (own + k) % n;
         if (elig[idx]) return idx;
      end
      return -1;
   endfunction

   // One clock: drive now (at negedge), model the edge, compare at next negedge.
   task automatic cyc(input logic [NA-1:0] ra, input bit da,
                      input logic [NB-1:0] rb, input bit db,
                      input bit we, input logic [31:0] wd);
      string ta, tb_;
      int p;
      a_req = ra; a_done = da; b_req = rb; b_done = db;
      cfg_we = we; cfg_wdata = wd;
      @(posedge clk);
      ta = "R3"; tb_ = "R3";
      if (da) begin
         p = pick(own_a, 16'(ra & ~reg_m[NA-1:0]), NA);
         if (p >= 0) begin own_a = p; vld_a = 1'b1; ta = "R4"; end
         else begin vld_a = 1'b0; ta = "R5"; end
      end
      if (db) begin
         p = pick(own_b, 16'(rb & ~reg_m[16 +: NB]), NB);
         if (p >= 0) begin own_b = p; vld_b = 1'b1; tb_ = "R4"; end
         else begin vld_b = 1'b0; tb_ = "R5"; end
      end
      if (we) reg_m = wd & IMPL;
      @(negedge clk);
      a_done = 1'b0; b_done = 1'b0; cfg_we = 1'b0;
      chk({ta, " bus A grant"}, 32'(a_gnt), 32'(1) << own_a);
      chk({ta, " bus A valid"}, 32'(a_gnt_vld), 32'(vld_a));
      chk({tb_, " bus B grant"}, 32'(b_gnt), 32'(1) << own_b);
      chk({tb_, " bus B valid"}, 32'(b_gnt_vld), 32'(vld_b));
      chk("R2 onehot A", $countones(a_gnt), 1);
      chk("R2 onehot B", $countones(b_gnt), 1);
      chk("R10 register readback", cfg_rdata, reg_m);
   endtask

   task automatic wr(input logic [31:0] wd);
      cyc('0, 1'b0, '0, 1'b0, 1'b1, wd);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      own_a = 0; own_b = 0; vld_a = 0; vld_b = 0; reg_m = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 bus A grant", 32'(a_gnt), 32'h1);
      chk("R1 bus A valid", 32'(a_gnt_vld), 0);
      chk("R1 bus B grant", 32'(b_gnt), 32'h1);
      chk("R1 bus B valid", 32'(b_gnt_vld), 0);
      chk("R1 register", cfg_rdata, 32'h0);

      // R10 / R9: reserved bits read zero, implemented bits read back
      wr(32'hFFFF_FFFF);
      chk("R10 all-ones write", cfg_rdata, IMPL);
      wr(32'h0000_0000);
      chk("R10 clear", cfg_rdata, 32'h0);

      // R4: round-robin order among 3 and 7 starting from owner 0
      cyc(NA'(12'h088), 1'b1, '0, 1'b0, 1'b0, '0);
      chk("R4 first pick", 32'(a_gnt), 32'h008);
      cyc(NA'(12'h088), 1'b1, '0, 1'b0, 1'b0, '0);
      chk("R4 second pick", 32'(a_gnt), 32'h080);
      cyc(NA'(12'h088), 1'b1, '0, 1'b0, 1'b0, '0);
      chk("R4 wrap pick", 32'(a_gnt), 32'h008);
      // R3: requests without done do not move the grant
      cyc(NA'(12'h080), 1'b0, '0, 1'b0, 1'b0, '0);
      chk("R3 no done", 32'(a_gnt), 32'h008);

      // R7: disable parked owner 3 (control bit 3)
      wr(32'h0000_0008);
      cyc('0, 1'b1, '0, 1'b0, 1'b0, '0);
      cyc('0, 1'b1, '0, 1'b0, 1'b0, '0);
      chk("R7 parked disabled owner keeps grant", 32'(a_gnt), 32'h008);
      chk("R5 parked valid low", 32'(a_gnt_vld), 0);
      // R8: only the disabled owner requests
      cyc(NA'(12'h008), 1'b1, '0, 1'b0, 1'b0, '0);
      chk("R8 disabled-only request keeps owner", 32'(a_gnt), 32'h008);
      // R7: enabled initiator 5 requests, owner loses
      cyc(NA'(12'h028), 1'b1, '0, 1'b0, 1'b0, '0);
      chk("R7 owner loses to enabled requester", 32'(a_gnt), 32'h020);
      chk("R7 valid after win", 32'(a_gnt_vld), 1);

      // R6: initiator 7 disabled, 7 and 9 request from owner 5 -> 9
      wr(32'h0000_0080);
      cyc(NA'(12'h280), 1'b1, '0, 1'b0, 1'b0, '0);
      chk("R6 disabled skipped", 32'(a_gnt), 32'h200);

      // R8: every requester disabled
      wr(32'h0000_0FFF);
      cyc(NA'(12'hA5A), 1'b1, '0, 1'b0, 1'b0, '0);
      chk("R8 all disabled", 32'(a_gnt), 32'h200);

      // R6: write landing on the arbitration edge uses the old mask
      cyc(NA'(12'h001), 1'b1, '0, 1'b0, 1'b1, 32'h0000_0FFF);
      chk("R6 same-edge write", 32'(a_gnt), 32'h200);
      cyc(NA'(12'h001), 1'b1, '0, 1'b0, 1'b1, 32'h0000_0000);
      chk("R6 old mask used", 32'(a_gnt), 32'h200);
      cyc(NA'(12'h001), 1'b1, '0, 1'b0, 1'b0, '0);
      chk("R6 new mask used", 32'(a_gnt), 32'h001);

      // R9 / R11: high-half bit 16+2 disables bus B initiator 2 only
      wr(32'h0004_0000);
      cyc(NA'(12'h004), 1'b0, NB'(10'h00C), 1'b1, 1'b0, '0);
      chk("R9 bus B bit 18 skips initiator 2", 32'(b_gnt), 32'h008);
      chk("R11 bus A untouched", 32'(a_gnt), 32'h001);
      cyc(NA'(12'h004), 1'b1, '0, 1'b0, 1'b0, '0);
      chk("R9 bus A initiator 2 enabled", 32'(a_gnt), 32'h004);
      chk("R11 bus B untouched", 32'(b_gnt), 32'h008);
      wr(32'h0);

      // Random phase, writes mixed into arbitrations
      for (int n = 0; n < 4000; n++) begin
         logic [NA-1:0] ra;
         logic [NB-1:0] rb;
         bit we;
         ra = NA'($urandom) & NA'($urandom);
         rb = NB'($urandom) & NB'($urandom);
         if ($urandom_range(3) == 0) ra = '0;
         we = ($urandom_range(15) == 0);
         cyc(ra, bit'($urandom_range(1)), rb, bit'($urandom_range(1)),
             we, $urandom & $urandom);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule